// File: doc/BRIEF.md
# UART Hardware Autoflow Controller

This block adds automatic RTS/CTS handshaking to a UART whose receive side buffers characters in a 16-entry FIFO. It compares the receive FIFO fill level against a programmable trigger level and drives an active-low RTS output from a register. On the transmit side it brings the asynchronous active-low CTS input through a synchronizer and produces a transmit-permit signal. The transmitter consults this signal before it starts each new character.

Autoflow applies only while both the autoflow enable bit and FIFO mode are set. Otherwise RTS follows the software request bit, and the transmitter is always permitted to send. While autoflow is active, the block also raises a mask that suppresses the modem-status interrupt for CTS changes. The serial shifters, the baud generator and the host register decode are outside this block. They supply the occupancy count, the read strobe and the character-timing strobes.

Top module: `uart_autoflow_ctrl`

## Requirements
- R1: After reset, `rts_n` is 1 (inactive) and `tx_permit` is 0.
- R2: With autoflow active and `trig_sel` encoded 0→1, 1→4, 2→8 entries, `rts_n` is 1 in the cycle after `rx_count` is at or above the selected level.
- R3: For those three levels, once released, `rts_n` stays 1 while `rx_count` is nonzero and returns to 0 in the cycle after `rx_count` is 0.
- R4: With `trig_sel` = 3 (14 entries), `rts_n` is 1 in the cycle after `rx_first_bit` pulses while `rx_count` is 15. The count reaching 14 alone does not release RTS.
- R5: With `trig_sel` = 3, a host read pulse (`rx_read`) that does not coincide with the R4 release condition makes `rts_n` 0 in the next cycle.
- R6: CTS passes through a two-flop synchronizer. With autoflow active and no character in progress (`tx_busy` = 0), `tx_permit` equals the inverse of `cts_n` as driven three clock edges earlier.
- R7: While `tx_busy` = 1, `tx_permit` changes only at a `tx_stop_mid` pulse, where it takes the synchronized CTS state. A CTS drop at any other point of a character does not affect `tx_permit` until that pulse.
- R8: With autoflow inactive (`afc_en` = 0 or `fifo_mode` = 0), `rts_n` is the inverse of `sw_rts` one cycle later and `tx_permit` is 1 one cycle later.
- R9: `msr_cts_mask` equals `afc_en` AND `fifo_mode`, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| afc_en | input | 1 | Autoflow enable bit |
| fifo_mode | input | 1 | FIFO mode enabled |
| sw_rts | input | 1 | Software RTS request (1 = assert RTS) |
| trig_sel | input | 2 | Receive trigger select: 0=1, 1=4, 2=8, 3=14 entries |
| rx_count | input | 5 | Receive FIFO occupancy, 0 to 16 |
| rx_read | input | 1 | Host read pulse on the receive FIFO |
| rx_first_bit | input | 1 | Pulse when the first data bit of an incoming character is on the line |
| tx_busy | input | 1 | Transmitter is sending a character |
| tx_stop_mid | input | 1 | Pulse at the midpoint of the last stop bit |
| cts_n | input | 1 | Asynchronous active-low CTS |
| rts_n | output | 1 | Registered active-low RTS |
| tx_permit | output | 1 | Transmitter may start the next character |
| msr_cts_mask | output | 1 | Suppress CTS-change modem-status interrupt |

## Verification
The bench runs the receive count up to each low trigger level and back down. A design that restores RTS on any read, rather than at empty, shows `rts_n` falling early in the drain phase. At level 14 it pulses the first-bit strobe at counts 14 and 15 and issues reads at full. A design that releases at the plain count threshold, or waits for an empty FIFO, drifts from the model there. CTS is toggled both between characters and in the middle of a character. A wrong synchronizer depth or a permit that tracks CTS live during a character then mismatches cycle by cycle.

// File: rtl/uart_afc_pkg.sv
package uart_afc_pkg;
   typedef enum logic [1:0] {
      TRIG_ONE      = 2'd0,
      TRIG_FOUR     = 2'd1,
      TRIG_EIGHT    = 2'd2,
      TRIG_FOURTEEN = 2'd3
   } trig_sel_e;
endpackage

// File: rtl/uart_afc_cts_sync.sv
module uart_afc_cts_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cts_n_async,
   output logic cts_ok
);
   if (STAGES < 2) begin : g_bad_stages
      $error("uart_afc_cts_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= 1'b0;
            else        chain_q[0] <= ~cts_n_async;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[i] <= 1'b0;
            else        chain_q[i] <= chain_q[i-1];
         end
      end
   end

   assign cts_ok = chain_q[STAGES-1];
endmodule

// File: rtl/uart_afc_rts_ctl.sv
module uart_afc_rts_ctl
   import uart_afc_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             sw_rts,
   input  logic [1:0]       trig,
   input  logic [CNT_W-1:0] rx_count,
   input  logic             rx_first_bit,
   input  logic             rx_read,
   output logic             rts_n
);
   localparam logic [CNT_W-1:0] LVL_ONE   = CNT_W'(1);
   localparam logic [CNT_W-1:0] LVL_FOUR  = CNT_W'(4);
   localparam logic [CNT_W-1:0] LVL_EIGHT = CNT_W'(8);
   localparam logic [CNT_W-1:0] NEAR_FULL = CNT_W'(DEPTH - 1);

   trig_sel_e        sel;
   logic [CNT_W-1:0] level;
   logic             low_mode;
   logic             early_rel;
   logic             hold_q, hold_d;

   assign sel       = trig_sel_e'(trig);
   assign low_mode  = (sel != TRIG_FOURTEEN);
   assign early_rel = rx_first_bit && (rx_count == NEAR_FULL);

   always_comb begin
      unique case (sel)
         TRIG_ONE:   level = LVL_ONE;
         TRIG_FOUR:  level = LVL_FOUR;
         TRIG_EIGHT: level = LVL_EIGHT;
         default:    level = NEAR_FULL;
      endcase
   end

   always_comb begin
      hold_d = hold_q;
      if (!active)                              hold_d = 1'b0;
      else if (low_mode && rx_count >= level)   hold_d = 1'b1;
      else if (low_mode && rx_count == '0)      hold_d = 1'b0;
      else if (!low_mode && early_rel)          hold_d = 1'b1;
      else if (!low_mode && rx_read)            hold_d = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= 1'b0;
         rts_n  <= 1'b1;
      end else begin
         hold_q <= hold_d;
         rts_n  <= active ? hold_d : ~sw_rts;
      end
   end

   p_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (active && low_mode && rx_count >= level) |=> rts_n);
   p_hold_until_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (active && low_mode && hold_q && rx_count != '0) |=> rts_n);
   p_early_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !low_mode && early_rel) |=> rts_n);
   p_restore_on_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !low_mode && rx_read && !early_rel) |=> !rts_n);
   p_manual_rts_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!active) |=> (rts_n == !$past(sw_rts)));
endmodule

// File: rtl/uart_afc_tx_gate.sv
module uart_afc_tx_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic cts_ok,
   input  logic tx_busy,
   input  logic tx_stop_mid,
   output logic tx_permit
);
   logic permit_d;

   always_comb begin
      if (!active)                     permit_d = 1'b1;
      else if (!tx_busy || tx_stop_mid) permit_d = cts_ok;
      else                             permit_d = tx_permit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tx_permit <= 1'b0;
      else        tx_permit <= permit_d;
   end

   p_midchar_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (active && tx_busy && !tx_stop_mid) |=> $stable(tx_permit));
   p_idle_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !tx_busy) |=> (tx_permit == $past(cts_ok)));
   p_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!active) |=> tx_permit);
endmodule

// File: rtl/uart_autoflow_ctrl.sv
module uart_autoflow_ctrl #(
   parameter int DEPTH       = 16,
   parameter int SYNC_STAGES = 2,
   parameter int CNT_W       = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             afc_en,
   input  logic             fifo_mode,
   input  logic             sw_rts,
   input  logic [1:0]       trig_sel,
   input  logic [CNT_W-1:0] rx_count,
   input  logic             rx_read,
   input  logic             rx_first_bit,
   input  logic             tx_busy,
   input  logic             tx_stop_mid,
   input  logic             cts_n,
   output logic             rts_n,
   output logic             tx_permit,
   output logic             msr_cts_mask
);
   if (DEPTH < 16) begin : g_bad_depth
      $error("uart_autoflow_ctrl: DEPTH must cover the top trigger level");
   end

   logic active;
   logic cts_ok;

   assign active       = afc_en && fifo_mode;
   assign msr_cts_mask = active;

   uart_afc_cts_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk         (clk),
      .rst_n       (rst_n),
      .cts_n_async (cts_n),
      .cts_ok      (cts_ok)
   );

   uart_afc_rts_ctl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_rts (
      .clk          (clk),
      .rst_n        (rst_n),
      .active       (active),
      .sw_rts       (sw_rts),
      .trig         (trig_sel),
      .rx_count     (rx_count),
      .rx_first_bit (rx_first_bit),
      .rx_read      (rx_read),
      .rts_n        (rts_n)
   );

   uart_afc_tx_gate u_gate (
      .clk         (clk),
      .rst_n       (rst_n),
      .active      (active),
      .cts_ok      (cts_ok),
      .tx_busy     (tx_busy),
      .tx_stop_mid (tx_stop_mid),
      .tx_permit   (tx_permit)
   );

   p_mask_tracks_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (msr_cts_mask == (afc_en && fifo_mode)));
endmodule

// File: tb/uart_autoflow_ctrl_bench.sv
`timescale 1ns/100ps
module uart_autoflow_ctrl_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic afc_en = 0, fifo_mode = 0, sw_rts = 0;
   logic [1:0] trig_sel = 0;
   logic [4:0] rx_count = 0;
   logic rx_read = 0, rx_first_bit = 0, tx_busy = 0, tx_stop_mid = 0;
   logic cts_n = 1;
   logic rts_n, tx_permit, msr_cts_mask;

   int checks = 0;
   int fails = 0;
   int cycles = 0;

   // reference model state
   bit m_hold = 0, m_rts_n = 1, m_permit = 0, m_c1 = 0, m_c2 = 0;
   bit run_cmp = 0;

   always #2.5 clk = ~clk;

   uart_autoflow_ctrl u_uart_autoflow_ctrl (
      .clk(clk), .rst_n(rst_n), .afc_en(afc_en), .fifo_mode(fifo_mode),
      .sw_rts(sw_rts), .trig_sel(trig_sel), .rx_count(rx_count),
      .rx_read(rx_read), .rx_first_bit(rx_first_bit), .tx_busy(tx_busy),
      .tx_stop_mid(tx_stop_mid), .cts_n(cts_n), .rts_n(rts_n),
      .tx_permit(tx_permit), .msr_cts_mask(msr_cts_mask));

   always @(posedge clk) begin
      bit act;
      int lvl;
      act = afc_en && fifo_mode;
      lvl = (trig_sel == 0) ? 1 : (trig_sel == 1) ? 4 : (trig_sel == 2) ? 8 : 14;
      if (!rst_n) begin
         m_hold = 0; m_rts_n = 1; m_permit = 0; m_c1 = 0; m_c2 = 0;
      end else begin
         if (!act) m_hold = 0;
         else if (trig_sel != 3) begin
            if (rx_count >= lvl) m_hold = 1;
            else if (rx_count == 0) m_hold = 0;
         end else begin
            if (rx_first_bit && rx_count == 15) m_hold = 1;
            else if (rx_read) m_hold = 0;
         end
         m_rts_n = act ? m_hold : !sw_rts;
         if (!act) m_permit = 1;
         else if (!tx_busy || tx_stop_mid) m_permit = m_c2;
         m_c2 = m_c1;
         m_c1 = !cts_n;
      end
   end

   task automatic check(input string tag, input logic act_v, input logic exp_v);
      checks++;
      if (act_v !== exp_v) begin
         fails++;
         $display("FAIL %s at cycle %0d: actual %b expected %b", tag, cycles, act_v, exp_v);
      end
   endtask

   always @(negedge clk) begin
      cycles++;
      if (run_cmp) begin
         if (!(afc_en && fifo_mode)) begin
            check("R8 rts", rts_n, m_rts_n);
            check("R8 permit", tx_permit, m_permit);
         end else begin
            check(trig_sel == 3 ? "R4/R5 rts" : "R2/R3 rts", rts_n, m_rts_n);
            check(tx_busy ? "R7 permit" : "R6 permit", tx_permit, m_permit);
         end
         check("R9 mask", msr_cts_mask, afc_en && fifo_mode);
      end
   end

   task automatic step(input int n = 1);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic ramp(input int lvl);
      for (int i = 0; i <= lvl; i++) begin rx_count = 5'(i); step(2); end
      check("R2 released at level", rts_n, 1'b1);
      for (int i = lvl; i >= 1; i--) begin
         rx_count = 5'(i); rx_read = 1; step(1); rx_read = 0; step(1);
         check("R3 held while nonempty", rts_n, 1'b1);
      end
      rx_count = 0; step(1);
      check("R3 restored at empty", rts_n, 1'b0);
   endtask

   initial begin
      step(3);
      check("R1 rts_n reset", rts_n, 1'b1);
      check("R1 permit reset", tx_permit, 1'b0);
      rst_n = 1; run_cmp = 1;
      // R8: software RTS while autoflow inactive
      sw_rts = 1; step(2);
      check("R8 sw rts on", rts_n, 1'b0);
      check("R8 permit bypass", tx_permit, 1'b1);
      afc_en = 1; rx_count = 16; cts_n = 1; tx_busy = 1; step(4);
      check("R8 fifo off ignores count", rts_n, 1'b0);
      sw_rts = 0; step(1);
      check("R8 sw rts off", rts_n, 1'b1);
      rx_count = 0; tx_busy = 0; fifo_mode = 1; step(2);
      check("R9 mask on", msr_cts_mask, 1'b1);
      // low trigger levels
      trig_sel = 0; ramp(1);
      trig_sel = 1; ramp(4);
      trig_sel = 2; ramp(8);
      // level 14
      trig_sel = 3;
      for (int i = 0; i <= 14; i++) begin rx_count = 5'(i); step(1); end
      check("R4 no release at 14", rts_n, 1'b0);
      rx_first_bit = 1; step(1); rx_first_bit = 0; step(1);
      check("R4 no release on first bit at 14", rts_n, 1'b0);
      rx_count = 15; step(1);
      rx_first_bit = 1; step(1); rx_first_bit = 0;
      check("R4 early release", rts_n, 1'b1);
      rx_count = 16; step(3);
      check("R4 holds at full", rts_n, 1'b1);
      rx_read = 1; step(1); rx_read = 0; rx_count = 15;
      check("R5 restore after read", rts_n, 1'b0);
      rx_count = 0; step(2);
      // CTS idle tracking
      trig_sel = 0;
      cts_n = 0; step(2);
      check("R6 sync not yet through", tx_permit, 1'b0);
      step(1);
      check("R6 permit after sync", tx_permit, 1'b1);
      // mid-character drop
      tx_busy = 1; step(2);
      cts_n = 1; step(6);
      check("R7 no change mid-char", tx_permit, 1'b1);
      tx_stop_mid = 1; step(1); tx_stop_mid = 0;
      check("R7 latched at stop mid", tx_permit, 1'b0);
      cts_n = 0; step(6);
      check("R7 holds off until next stop mid", tx_permit, 1'b0);
      tx_stop_mid = 1; step(1); tx_stop_mid = 0;
      check("R7 re-permit at stop mid", tx_permit, 1'b1);
      tx_busy = 0; step(2);
      for (int i = 0; i < 40; i++) begin
         cts_n = i[1]; tx_busy = i[2]; tx_stop_mid = (i % 5 == 0);
         rx_count = 5'(i % 17); step(1);
      end
      tx_stop_mid = 0; afc_en = 0; step(3);
      check("R9 mask off", msr_cts_mask, 1'b0);
      run_cmp = 0;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(5ns * 100000);
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule